// File: doc/BRIEF.md
# Endpoint Stream Buffer Manager

This block moves streaming payload between the serial bus engine and circular buffers held in processor memory, for every endpoint except the control endpoint. Firmware sets up each endpoint once through a configuration port. After that, no firmware takes part in the data path. Endpoints 1 to 3 are reserved for downloading processor code, so they only accept host-to-device traffic. Endpoints 4 to 11 carry processor data in either direction.

Each endpoint has a settings word and four buffer registers: a start address, a size in words, a read position and a write position. When a token arrives, the block looks up the addressed endpoint and gives one of three verdicts:

- **stall** when the endpoint cannot accept the token;
- **not-ready** when the buffer has no room or no data;
- **grant** when the transfer may go ahead.

Each payload word of a granted packet becomes one memory strobe with a word address. The buffer position moves forward only when the link reports that the packet ended cleanly. A packet that fails is therefore written again to the same locations on retry.

Top module: `epbuf_mgr`

## Requirements
- R1: After reset, every output is 0, and every endpoint is unconfigured, so any token draws a stall.
- R2: A token is stalled in any of these cases: its endpoint number is 0 or above 11; the endpoint is disabled; the endpoint's type is control (code 0); its direction bit differs from the token (1 = device-to-host); or it is a device-to-host token for endpoints 1 to 3. The verdict pulses for one cycle, one cycle after the token.
- R3: A host-to-device token is granted when free space, defined as size − 1 − fill, is at least the maximum packet size. Otherwise the block pulses not-ready and leaves both positions unchanged. Fill is (write − read) taken modulo size.
- R4: A device-to-host token is granted when fill is non-zero. Otherwise the block pulses not-ready.
- R5: Each payload beat of a granted host-to-device packet produces a write strobe one cycle later. That strobe carries the current write position as its address and the beat's data as its write data. Address and write data are 0 in every cycle that has no strobe.
- R6: Each beat of a granted device-to-host packet produces a read strobe one cycle later, at the current read position. This continues up to min(maximum packet size, fill) beats. Any later beats produce no strobe.
- R7: A position that steps onto start + size goes back to the start address.
- R8: A host-to-device beat that arrives after the maximum packet size has been reached makes no write. It sets that endpoint's bit in the error vector (bit e−1 for endpoint e). Only a write to that endpoint's settings word clears the bit.
- R9: An end-of-packet with the good flag set commits the advanced position. Without the good flag, the position is unchanged, so a retry uses the same addresses.
- R10: Isochronous (1), bulk (2) and interrupt (3) types are all granted.
- R11: A token that arrives while a packet is in progress produces no verdict.
- R12: Configuration selectors are: 0 settings, 1 start, 2 size, 3 read position, 4 write position. The settings word is laid out as bit 15 enable, bit 14 direction, bits 13:12 type, and bits 11:0 maximum packet size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ep | input | 4 | Endpoint being configured |
| cfg_sel | input | 3 | Register selector |
| cfg_wdata | input | 16 | Configuration value |
| tok_valid | input | 1 | Token present |
| tok_ep | input | 4 | Token endpoint number |
| tok_in | input | 1 | Token is device-to-host |
| beat_valid | input | 1 | Payload word present |
| beat_data | input | 16 | Payload word |
| pkt_end | input | 1 | Packet finished |
| pkt_good | input | 1 | Packet finished without error |
| stall_o | output | 1 | Stall verdict pulse |
| nak_o | output | 1 | Not-ready verdict pulse |
| grant_o | output | 1 | Grant verdict pulse |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| ep_err | output | 11 | Oversize flags, bit e−1 for endpoint e |

## Verification
Every registered result arrives exactly one cycle after the edge that sampled its cause:

- a verdict follows its token;
- a strobe follows its beat;
- an error bit follows the offending beat;
- a committed position first affects the token after the end-of-packet.

The behavioural model in the bench computes what each edge should produce from the inputs it sees at that edge. It compares the outputs at the next falling edge, so each result is checked in the one cycle it is due and in no other.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;
    typedef enum logic [1:0] {
        XF_CTRL = 2'd0,
        XF_ISO  = 2'd1,
        XF_BULK = 2'd2,
        XF_INTR = 2'd3
    } xfer_e;

    typedef enum logic [1:0] {
        VD_NONE  = 2'd0,
        VD_GRANT = 2'd1,
        VD_NAK   = 2'd2,
        VD_STALL = 2'd3
    } verdict_e;

    // R12 register selectors
    localparam logic [2:0] CS_CTRL = 3'd0;
    localparam logic [2:0] CS_BASE = 3'd1;
    localparam logic [2:0] CS_LEN  = 3'd2;
    localparam logic [2:0] CS_RDP  = 3'd3;
    localparam logic [2:0] CS_WRP  = 3'd4;

    // R12 settings-word layout
    localparam int CTRL_EN_BIT   = 15;
    localparam int CTRL_DIR_BIT  = 14;
    localparam int CTRL_TYPE_LSB = 12;
endpackage

// File: rtl/epbuf_cfg_bank.sv
module epbuf_cfg_bank
    import epbuf_pkg::*;
#(
    parameter int NUM_EP = 11,
    parameter int ADDR_W = 16,
    parameter int MPS_W  = 12,
    parameter int EP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [EP_W-1:0]   cfg_ep,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              cm_we,
    input  logic [EP_W-1:0]   cm_ep,
    input  logic              cm_in,
    input  logic [ADDR_W-1:0] cm_ptr,
    input  logic              err_set,
    input  logic [EP_W-1:0]   err_ep,
    input  logic [EP_W-1:0]   lk_ep,
    output logic              lk_en,
    output logic              lk_dir,
    output xfer_e             lk_type,
    output logic [MPS_W-1:0]  lk_mps,
    output logic [ADDR_W-1:0] lk_base,
    output logic [ADDR_W-1:0] lk_len,
    output logic [ADDR_W-1:0] lk_rdp,
    output logic [ADDR_W-1:0] lk_wrp,
    output logic [NUM_EP-1:0] err_vec
);
    typedef struct packed {
        logic              en;
        logic              dir;
        xfer_e             xtype;
        logic [MPS_W-1:0]  mps;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] len;
        logic [ADDR_W-1:0] rdp;
        logic [ADDR_W-1:0] wrp;
        logic              err;
    } ep_rec_t;

    ep_rec_t rec_q [1:NUM_EP];
    ep_rec_t rec_d [1:NUM_EP];
    ep_rec_t lk_rec;

    always_comb begin
        for (int e = 1; e <= NUM_EP; e++) begin
            rec_d[e] = rec_q[e];
            // R9 commit of the advanced position
            if (cm_we && cm_ep == EP_W'(e)) begin
                if (cm_in) rec_d[e].rdp = cm_ptr;
                else       rec_d[e].wrp = cm_ptr;
            end
            // R8 oversize flag
            if (err_set && err_ep == EP_W'(e)) rec_d[e].err = 1'b1;
            if (cfg_we && cfg_ep == EP_W'(e)) begin
                case (cfg_sel)
                    CS_CTRL: begin
                        rec_d[e].en    = cfg_wdata[CTRL_EN_BIT];
                        rec_d[e].dir   = cfg_wdata[CTRL_DIR_BIT];
                        rec_d[e].xtype = xfer_e'(cfg_wdata[CTRL_TYPE_LSB +: 2]);
                        rec_d[e].mps   = cfg_wdata[MPS_W-1:0];
                        rec_d[e].err   = 1'b0;
                    end
                    CS_BASE: rec_d[e].base = cfg_wdata;
                    CS_LEN:  rec_d[e].len  = cfg_wdata;
                    CS_RDP:  rec_d[e].rdp  = cfg_wdata;
                    CS_WRP:  rec_d[e].wrp  = cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 1; e <= NUM_EP; e++) rec_q[e] <= '0;   // R1
        end else begin
            for (int e = 1; e <= NUM_EP; e++) rec_q[e] <= rec_d[e];
        end
    end

    always_comb begin
        lk_rec = '0;
        for (int e = 1; e <= NUM_EP; e++) begin
            if (lk_ep == EP_W'(e)) lk_rec = rec_q[e];
        end
    end

    assign lk_en   = lk_rec.en;
    assign lk_dir  = lk_rec.dir;
    assign lk_type = lk_rec.xtype;
    assign lk_mps  = lk_rec.mps;
    assign lk_base = lk_rec.base;
    assign lk_len  = lk_rec.len;
    assign lk_rdp  = lk_rec.rdp;
    assign lk_wrp  = lk_rec.wrp;

    for (genvar g = 1; g <= NUM_EP; g++) begin : g_err
        assign err_vec[g-1] = rec_q[g].err;
    end
endmodule

// File: rtl/epbuf_admit.sv
module epbuf_admit
    import epbuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MPS_W  = 12
) (
    input  logic              tok_in,
    input  logic              ep_hit,
    input  logic              is_code,
    input  logic              en,
    input  logic              dir,
    input  xfer_e             xtype,
    input  logic [MPS_W-1:0]  mps,
    input  logic [ADDR_W-1:0] len,
    input  logic [ADDR_W-1:0] rdp,
    input  logic [ADDR_W-1:0] wrp,
    output verdict_e          verdict,
    output logic [ADDR_W-1:0] start_ptr,
    output logic [MPS_W:0]    limit
);
    logic [ADDR_W-1:0] fill;
    logic [ADDR_W-1:0] room;
    logic [ADDR_W-1:0] mps_w;
    logic              refuse;

    assign mps_w = ADDR_W'(mps);
    assign fill  = (wrp >= rdp) ? (wrp - rdp) : (wrp + len - rdp);
    assign room  = len - 1'b1 - fill;

    // R2 stall conditions
    assign refuse = !ep_hit || !en || (xtype == XF_CTRL) ||
                    (dir != tok_in) || (tok_in && is_code);

    always_comb begin
        verdict   = VD_GRANT;
        start_ptr = tok_in ? rdp : wrp;
        limit     = {1'b0, mps};
        if (refuse) begin
            verdict = VD_STALL;
        end else if (tok_in) begin
            if (fill == '0) verdict = VD_NAK;                        // R4
            if (mps_w > fill) limit = fill[MPS_W:0];                 // R6
        end else if (mps_w > room) begin
            verdict = VD_NAK;                                        // R3
        end
    end
endmodule

// File: rtl/epbuf_ptr_step.sv
module epbuf_ptr_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] len,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] inc;
    assign inc = cur + 1'b1;
    assign nxt = (inc == base + len) ? base : inc;   // R7
endmodule

// File: rtl/epbuf_mgr.sv
module epbuf_mgr
    import epbuf_pkg::*;
#(
    parameter int NUM_EP      = 11,
    parameter int NUM_CODE_EP = 3,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int MPS_W       = 12,
    localparam int EP_W       = $clog2(NUM_EP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [EP_W-1:0]   cfg_ep,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              tok_valid,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              tok_in,
    input  logic              beat_valid,
    input  logic [DATA_W-1:0] beat_data,
    input  logic              pkt_end,
    input  logic              pkt_good,
    output logic              stall_o,
    output logic              nak_o,
    output logic              grant_o,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [NUM_EP-1:0] ep_err
);
    typedef struct packed {
        logic              active;
        logic              dir_in;
        logic [EP_W-1:0]   ep;
        logic [ADDR_W-1:0] cur;
        logic [MPS_W:0]    cnt;
        logic [MPS_W:0]    lim;
        logic              stall;
        logic              nak;
        logic              grant;
        logic              we;
        logic              re;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } st_t;

    st_t st_d, st_q;

    logic [EP_W-1:0]   lk_ep;
    logic              lk_en, lk_dir;
    xfer_e             lk_type;
    logic [MPS_W-1:0]  lk_mps;
    logic [ADDR_W-1:0] lk_base, lk_len, lk_rdp, lk_wrp;
    logic              ep_hit, is_code;
    verdict_e          verdict;
    logic [ADDR_W-1:0] start_ptr, cur_nx;
    logic [MPS_W:0]    limit;
    logic              cm_we, err_set;

    assign lk_ep   = st_q.active ? st_q.ep : tok_ep;
    assign ep_hit  = (tok_ep != '0) && (tok_ep <= EP_W'(NUM_EP));
    assign is_code = (tok_ep != '0) && (tok_ep <= EP_W'(NUM_CODE_EP));

    epbuf_cfg_bank #(
        .NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .MPS_W(MPS_W), .EP_W(EP_W)
    ) bank_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cm_we(cm_we), .cm_ep(st_q.ep), .cm_in(st_q.dir_in), .cm_ptr(st_d.cur),
        .err_set(err_set), .err_ep(st_q.ep),
        .lk_ep(lk_ep), .lk_en(lk_en), .lk_dir(lk_dir), .lk_type(lk_type),
        .lk_mps(lk_mps), .lk_base(lk_base), .lk_len(lk_len),
        .lk_rdp(lk_rdp), .lk_wrp(lk_wrp), .err_vec(ep_err)
    );

    epbuf_admit #(.ADDR_W(ADDR_W), .MPS_W(MPS_W)) admit_i (
        .tok_in(tok_in), .ep_hit(ep_hit), .is_code(is_code),
        .en(lk_en), .dir(lk_dir), .xtype(lk_type), .mps(lk_mps),
        .len(lk_len), .rdp(lk_rdp), .wrp(lk_wrp),
        .verdict(verdict), .start_ptr(start_ptr), .limit(limit)
    );

    epbuf_ptr_step #(.ADDR_W(ADDR_W)) step_i (
        .cur(st_q.cur), .base(lk_base), .len(lk_len), .nxt(cur_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.stall = 1'b0;
        st_d.nak   = 1'b0;
        st_d.grant = 1'b0;
        st_d.we    = 1'b0;
        st_d.re    = 1'b0;
        st_d.addr  = '0;
        st_d.wdata = '0;
        cm_we      = 1'b0;
        err_set    = 1'b0;
        if (st_q.active) begin
            // R11 tokens ignored here
            if (beat_valid) begin
                if (st_q.cnt < st_q.lim) begin
                    st_d.we    = !st_q.dir_in;                 // R5
                    st_d.re    = st_q.dir_in;                  // R6
                    st_d.addr  = st_q.cur;
                    st_d.wdata = st_q.dir_in ? '0 : beat_data;
                    st_d.cur   = cur_nx;
                    st_d.cnt   = st_q.cnt + 1'b1;
                end else if (!st_q.dir_in) begin
                    err_set = 1'b1;                            // R8
                end
            end
            if (pkt_end) begin
                cm_we       = pkt_good;                        // R9
                st_d.active = 1'b0;
            end
        end else if (tok_valid) begin
            case (verdict)
                VD_STALL: st_d.stall = 1'b1;
                VD_NAK:   st_d.nak   = 1'b1;
                VD_GRANT: begin                                // R10
                    st_d.grant  = 1'b1;
                    st_d.active = 1'b1;
                    st_d.dir_in = tok_in;
                    st_d.ep     = tok_ep;
                    st_d.cur    = start_ptr;
                    st_d.cnt    = '0;
                    st_d.lim    = limit;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;                                // R1
        else        st_q <= st_d;
    end

    assign stall_o   = st_q.stall;
    assign nak_o     = st_q.nak;
    assign grant_o   = st_q.grant;
    assign mem_we    = st_q.we;
    assign mem_re    = st_q.re;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.wdata;
endmodule

// File: rtl/epbuf_mgr_chk.sv
module epbuf_mgr_chk #(
    parameter int NUM_EP = 11,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              tok_valid,
    input logic              beat_valid,
    input logic              stall_o,
    input logic              nak_o,
    input logic              grant_o,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NUM_EP-1:0] ep_err
);
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stall_o, nak_o, grant_o})); // R2
    AST_VERDICT_FROM_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o || nak_o || grant_o) |-> $past(tok_valid)); // R11
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R5
    AST_STROBE_FROM_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> $past(beat_valid)); // R6
    AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we || mem_re) |-> (mem_addr == '0)); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(ep_err) & ~ep_err)) |-> $past(cfg_we)); // R8
endmodule

bind epbuf_mgr epbuf_mgr_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .tok_valid(tok_valid),
    .beat_valid(beat_valid), .stall_o(stall_o), .nak_o(nak_o),
    .grant_o(grant_o), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .ep_err(ep_err)
);

// File: tb/epbuf_mgr_tb.sv
module epbuf_mgr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_ep = '0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        tok_valid = 1'b0;
    logic [3:0]  tok_ep = '0;
    logic        tok_in = 1'b0;
    logic        beat_valid = 1'b0;
    logic [15:0] beat_data = '0;
    logic        pkt_end = 1'b0;
    logic        pkt_good = 1'b0;
    logic        stall_o, nak_o, grant_o, mem_we, mem_re;
    logic [15:0] mem_addr, mem_wdata;
    logic [10:0] ep_err;

    always #4 clk = ~clk;   // 125 MHz

    epbuf_mgr dut_i (.*);

    int    n_vec = 0;
    int    n_bad = 0;
    int    n_cyc = 0;
    string req_tag = "R1";

    // behavioural reference model
    int en[16], dir[16], typ[16], mps[16], bas[16], len[16], rdp[16], wrp[16], err[16];
    int act = 0, a_in = 0, a_ep = 0, cur = 0, cnt = 0, lim = 0;
    int x_stall = 0, x_nak = 0, x_grant = 0, x_we = 0, x_re = 0, x_addr = 0, x_wdata = 0;

    function automatic int step(int p, int b, int l);
        int n;
        n = (p + 1) & 16'hFFFF;
        if (n == ((b + l) & 16'hFFFF)) n = b;   // R7
        return n;
    endfunction

    always @(posedge clk) begin
        n_cyc++;
        x_stall = 0; x_nak = 0; x_grant = 0; x_we = 0; x_re = 0; x_addr = 0; x_wdata = 0;
        if (!rst_n) begin
            for (int e = 0; e < 16; e++) begin
                en[e] = 0; dir[e] = 0; typ[e] = 0; mps[e] = 0; bas[e] = 0;
                len[e] = 0; rdp[e] = 0; wrp[e] = 0; err[e] = 0;
            end
            act = 0;
        end else begin
            if (act != 0) begin
                if (beat_valid) begin
                    if (cnt < lim) begin
                        x_we = (a_in == 0); x_re = a_in; x_addr = cur;
                        x_wdata = a_in ? 0 : int'(beat_data);
                        cur = step(cur, bas[a_ep], len[a_ep]); cnt++;
                    end else if (a_in == 0) err[a_ep] = 1;
                end
                if (pkt_end) begin
                    if (pkt_good) begin
                        if (a_in != 0) rdp[a_ep] = cur; else wrp[a_ep] = cur;
                    end
                    act = 0;
                end
            end else if (tok_valid) begin
                int e, ok, fill;
                e = int'(tok_ep);
                ok = (e >= 1 && e <= 11) ? 1 : 0;
                if (ok != 0) ok = (en[e] != 0 && typ[e] != 0 && dir[e] == int'(tok_in)
                                  && !(tok_in && e <= 3)) ? 1 : 0;
                if (ok == 0) x_stall = 1;
                else begin
                    fill = (wrp[e] >= rdp[e]) ? wrp[e] - rdp[e] : (wrp[e] + len[e] - rdp[e]) & 16'hFFFF;
                    if (tok_in) begin
                        if (fill == 0) x_nak = 1;
                        else begin x_grant = 1; cur = rdp[e]; lim = (fill < mps[e]) ? fill : mps[e]; end
                    end else begin
                        if (len[e] - 1 - fill < mps[e]) x_nak = 1;
                        else begin x_grant = 1; cur = wrp[e]; lim = mps[e]; end
                    end
                    if (x_grant != 0) begin act = 1; a_in = int'(tok_in); a_ep = e; cnt = 0; end
                end
            end
            if (cfg_we && cfg_ep >= 1 && cfg_ep <= 11) begin
                int e; e = int'(cfg_ep);
                case (cfg_sel)
                    3'd0: begin en[e] = cfg_wdata[15]; dir[e] = cfg_wdata[14];
                                typ[e] = int'(cfg_wdata[13:12]); mps[e] = int'(cfg_wdata[11:0]);
                                err[e] = 0; end
                    3'd1: bas[e] = cfg_wdata;
                    3'd2: len[e] = cfg_wdata;
                    3'd3: rdp[e] = cfg_wdata;
                    3'd4: wrp[e] = cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic cmp(string nm, int act_v, int exp_v);
        n_vec++;
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, nm, act_v, exp_v);
        end
    endtask

    always @(negedge clk) begin
        if (n_cyc >= 1) begin
            int xe;
            xe = 0;
            for (int e = 1; e <= 11; e++) if (err[e] != 0) xe |= (1 << (e - 1));
            cmp("stall", int'(stall_o), x_stall);
            cmp("nak", int'(nak_o), x_nak);
            cmp("grant", int'(grant_o), x_grant);
            cmp("we", int'(mem_we), x_we);
            cmp("re", int'(mem_re), x_re);
            cmp("addr", int'(mem_addr), x_addr);
            cmp("wdata", int'(mem_wdata), x_wdata);
            cmp("err", int'(ep_err), xe);
        end
    end

    task automatic cfg(int e, int s, int d);
        @(negedge clk); cfg_we = 1; cfg_ep = 4'(e); cfg_sel = 3'(s); cfg_wdata = 16'(d);
        @(negedge clk); cfg_we = 0;
    endtask
    task automatic setup(int e, int ctl, int b, int l, int r, int w);
        cfg(e, 1, b); cfg(e, 2, l); cfg(e, 3, r); cfg(e, 4, w); cfg(e, 0, ctl);
    endtask
    task automatic tok(int e, int in);
        @(negedge clk); tok_valid = 1; tok_ep = 4'(e); tok_in = 1'(in);
        @(negedge clk); tok_valid = 0;
    endtask
    task automatic beats(int n, int d0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); beat_valid = 1; beat_data = 16'(d0 + i);
        end
        @(negedge clk); beat_valid = 0;
    endtask
    task automatic pend(int good);
        @(negedge clk); pkt_end = 1; pkt_good = 1'(good);
        @(negedge clk); pkt_end = 0;
    endtask
    task automatic pkt(int e, int in, int n, int d0, int good);
        tok(e, in); beats(n, d0); pend(good);
    endtask

    initial begin
        req_tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        tok(4, 0);                               // R1 unconfigured -> stall
        req_tag = "R12";
        setup(4, 16'hA004, 16'h0100, 12, 16'h0100, 16'h0100);
        setup(5, 16'hD003, 16'h0200, 6, 16'h0200, 16'h0204);
        setup(6, 16'hF002, 16'h0300, 4, 16'h0300, 16'h0302);
        setup(1, 16'hA008, 16'h0400, 16, 16'h040E, 16'h040E);
        setup(7, 16'h8004, 16'h0500, 8, 16'h0500, 16'h0500);
        req_tag = "R2";
        tok(0, 0); tok(12, 0); tok(4, 1); tok(7, 0); tok(9, 0); tok(1, 1);
        req_tag = "R5";
        pkt(4, 0, 4, 16'hA0, 1);
        req_tag = "R9";
        pkt(4, 0, 3, 16'hB0, 0);
        req_tag = "R11";
        tok(4, 0); tok(0, 0); beats(4, 16'hC0); pend(1);
        req_tag = "R3";
        tok(4, 0);
        req_tag = "R10";
        pkt(5, 1, 3, 0, 1);
        pkt(6, 1, 2, 0, 1);
        req_tag = "R6";
        pkt(5, 1, 3, 0, 1);
        req_tag = "R4";
        tok(5, 1); tok(6, 1);
        req_tag = "R7";
        pkt(1, 0, 4, 16'hD0, 1);
        req_tag = "R8";
        pkt(1, 0, 10, 16'hE0, 1);
        repeat (2) @(negedge clk);
        cfg(1, 0, 16'hA008);
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule